// File: doc/BRIEF.md
# Programmable delay tap controller

This block keeps the tap setting of a 32-position input delay line and moves it in response to commands sampled on a control clock. A parameter fixes one of four behaviours when the block is built: a constant setting, a setting that steps up or down with a reload to the build-time initial value, a stepping setting that can be loaded directly from a 5-bit count input, and a stepping setting that loads from a separately written staging register.

The current tap count is always visible on an output and changes only on a control clock edge, one cycle after the command is sampled. A staging register, written from the same count input, lets software prepare a new setting ahead of the load that applies it. So that the setting can be checked in logic, a history line delays a sampled data input by as many clock cycles as the tap count shows.

Top module: `tap_delay_ctrl`

## Requirements
- R1: After a synchronous active-low reset the tap count is INIT_TAP in fixed and plain stepping modes, and 0 in both load modes, where INIT_TAP is ignored.
- R2: In fixed mode the tap count stays at INIT_TAP whatever the step, direction and load inputs do.
- R3: In every stepping mode, step_en=1 with step_up=1 adds one to the tap count, and step_en=1 with step_up=0 subtracts one, on the next clock edge.
- R4: Stepping up from 31 gives 0, and stepping down from 0 gives 31.
- R5: In plain stepping mode, load_req=1 returns the tap count to INIT_TAP.
- R6: In direct-load mode, load_req=1 sets the tap count to load_val sampled on the same edge.
- R7: In staged-load mode, load_req=1 sets the tap count to the staging register contents held before that edge; a write in the same cycle does not affect the loaded value.
- R8: In staged-load mode, stage_wr=1 captures load_val into the staging register, shown on stage_out one cycle later; the staging register resets to 0 and reads 0 in every other mode.
- R9: When load_req and step_en are both 1, the load wins and the step is dropped.
- R10: With load_req=0 and step_en=0 the tap count holds its value.
- R11: data_out equals data_in when the tap count is 0, and otherwise the data_in value sampled tap-count clock edges earlier (history clears to 0 on reset).

Parameters: MODE (tap_mode_e), INIT_TAP (0..31, default 0), TAP_W (default 5), DATA_W (default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Step command enable |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| load_req | input | 1 | Load command strobe |
| load_val | input | TAP_W | Count input for direct load and staging writes |
| stage_wr | input | 1 | Staging register write strobe |
| data_in | input | DATA_W | Sampled data for the history line |
| tap_out | output | TAP_W | Current tap count |
| stage_out | output | TAP_W | Staging register contents |
| data_out | output | DATA_W | data_in delayed by tap_out clock cycles |

## Verification
The checker watches, on every cycle, the reset value, the fixed-mode hold, each single step and its wrap, the hold when idle, each mode's load source including load-over-step priority, and the staging register writes. What only the bench scenarios show is how these combine over long runs: the same command stream drives one instance of every mode side by side, and a behavioural model with a history queue predicts every tap count, staging value and delayed data word, including the same-cycle write and load and a reset in the middle of the run.

// File: rtl/tap_delay_pkg.sv
// Shared types for the tap delay controller.
// Assumes: tap modes are fixed at build time through a parameter.
package tap_delay_pkg;

    typedef enum logic [1:0] {
        TAPMODE_FIXED,
        TAPMODE_STEP,
        TAPMODE_STEP_DIRECT,
        TAPMODE_STEP_STAGED
    } tap_mode_e;

    typedef enum logic [1:0] {
        CMD_HOLD,
        CMD_UP,
        CMD_DOWN,
        CMD_LOAD
    } tap_cmd_e;

    // Reduces the raw strobes to one command; load outranks a step.
    function automatic tap_cmd_e decode_cmd(input logic load_req,
                                            input logic step_en,
                                            input logic step_up);
        if (load_req)     return CMD_LOAD;
        else if (step_en) return step_up ? CMD_UP : CMD_DOWN;
        else              return CMD_HOLD;
    endfunction

    // Reset value of the tap count for a given mode.
    function automatic int unsigned reset_tap(input tap_mode_e mode,
                                              input int unsigned init_tap);
        return (mode == TAPMODE_FIXED || mode == TAPMODE_STEP) ? init_tap : 0;
    endfunction

endpackage

// File: rtl/tap_stage_reg.sv
// Staging register for pre-loading a tap value.
// Captures wr_val when wr_en is high; the caller gates wr_en to zero
// in modes that have no staging register, so the output then stays 0.
module tap_stage_reg #(
    parameter int TAP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAP_W-1:0] wr_val,
    output logic [TAP_W-1:0] stage_q
);

    // Holds the staged value, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     stage_q <= '0;
        else if (wr_en) stage_q <= wr_val;
    end

endmodule

// File: rtl/tap_counter.sv
// Tap count register with mode-dependent load source and wrap-around steps.
// Assumes: direct_val and staged_val are valid in the cycle load_req is high.
module tap_counter
    import tap_delay_pkg::*;
#(
    parameter tap_mode_e   MODE     = TAPMODE_STEP,
    parameter int unsigned INIT_TAP = 0,
    parameter int          TAP_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             step_up,
    input  logic             load_req,
    input  logic [TAP_W-1:0] direct_val,
    input  logic [TAP_W-1:0] staged_val,
    output logic [TAP_W-1:0] tap_q
);

    localparam logic [TAP_W-1:0] RST_TAP = TAP_W'(reset_tap(MODE, INIT_TAP));

    tap_cmd_e         cmd;
    logic [TAP_W-1:0] stepped;
    logic [TAP_W-1:0] load_src;
    logic [TAP_W-1:0] tap_d;

    // Decodes the command and forms the stepped count (natural wrap).
    always_comb begin
        cmd = decode_cmd(load_req, step_en, step_up);
        unique case (cmd)
            CMD_UP:   stepped = tap_q + 1'b1;
            CMD_DOWN: stepped = tap_q - 1'b1;
            default:  stepped = tap_q;
        endcase
    end

    // Picks the load source that the build-time mode selects.
    always_comb begin
        unique case (MODE)
            TAPMODE_STEP_DIRECT: load_src = direct_val;
            TAPMODE_STEP_STAGED: load_src = staged_val;
            default:             load_src = RST_TAP;
        endcase
    end

    // Next count: fixed mode never moves, other modes load or step.
    always_comb begin
        if (MODE == TAPMODE_FIXED) tap_d = RST_TAP;
        else if (cmd == CMD_LOAD)  tap_d = load_src;
        else                       tap_d = stepped;
    end

    // Tap count register.
    always_ff @(posedge clk) begin
        if (!rst_n) tap_q <= RST_TAP;
        else        tap_q <= tap_d;
    end

endmodule

// File: rtl/tap_history_line.sv
// Shift line that delays a data word by a selectable number of cycles.
// Assumes: a tap of 0 means no delay (combinational pass-through).
module tap_history_line #(
    parameter int TAP_W  = 5,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAP_W-1:0]  tap_sel,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int HIST_N = (1 << TAP_W) - 1;

    logic [DATA_W-1:0] hist [HIST_N];

    // Shifts the history one place per clock; newest word at index 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HIST_N; i++) hist[i] <= '0;
        end else begin
            hist[0] <= din;
            for (int i = 1; i < HIST_N; i++) hist[i] <= hist[i-1];
        end
    end

    // Selects the word that is tap_sel cycles old.
    always_comb begin
        if (tap_sel == '0) dout = din;
        else               dout = hist[tap_sel - 1'b1];
    end

endmodule

// File: rtl/tap_delay_ctrl.sv
// Top of the tap delay controller: staging register, tap counter and
// a history line that makes the setting observable in cycles.
// Assumes: all inputs synchronous to clk; MODE and INIT_TAP fixed at build.
module tap_delay_ctrl
    import tap_delay_pkg::*;
#(
    parameter tap_mode_e   MODE     = TAPMODE_STEP,
    parameter int unsigned INIT_TAP = 0,
    parameter int          TAP_W    = 5,
    parameter int          DATA_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              step_up,
    input  logic              load_req,
    input  logic [TAP_W-1:0]  load_val,
    input  logic              stage_wr,
    input  logic [DATA_W-1:0] data_in,
    output logic [TAP_W-1:0]  tap_out,
    output logic [TAP_W-1:0]  stage_out,
    output logic [DATA_W-1:0] data_out
);

    localparam logic STAGE_EN = (MODE == TAPMODE_STEP_STAGED);

    logic stage_wr_g;

    // Staging writes only take effect in staged-load mode.
    assign stage_wr_g = stage_wr & STAGE_EN;

    tap_stage_reg #(
        .TAP_W (TAP_W)
    ) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (stage_wr_g),
        .wr_val  (load_val),
        .stage_q (stage_out)
    );

    tap_counter #(
        .MODE     (MODE),
        .INIT_TAP (INIT_TAP),
        .TAP_W    (TAP_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .step_up    (step_up),
        .load_req   (load_req),
        .direct_val (load_val),
        .staged_val (stage_out),
        .tap_q      (tap_out)
    );

    tap_history_line #(
        .TAP_W  (TAP_W),
        .DATA_W (DATA_W)
    ) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .tap_sel (tap_out),
        .din     (data_in),
        .dout    (data_out)
    );

endmodule

// File: rtl/tap_delay_chk.sv
// Protocol checker for tap_delay_ctrl, attached by bind below.
// Assumes: reset held low at time zero.
module tap_delay_chk
    import tap_delay_pkg::*;
#(
    parameter tap_mode_e   MODE     = TAPMODE_STEP,
    parameter int unsigned INIT_TAP = 0,
    parameter int          TAP_W    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_en,
    input logic             step_up,
    input logic             load_req,
    input logic [TAP_W-1:0] load_val,
    input logic             stage_wr,
    input logic [TAP_W-1:0] tap_out,
    input logic [TAP_W-1:0] stage_out
);

    localparam logic [TAP_W-1:0] RST_TAP = TAP_W'(reset_tap(MODE, INIT_TAP));

    AST_RESET_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> tap_out == RST_TAP); // R1

    if (MODE == TAPMODE_FIXED) begin : g_fixed
        AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            tap_out == RST_TAP); // R2
    end else begin : g_var
        AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
            (!load_req && step_en && step_up) |=> tap_out == TAP_W'($past(tap_out) + 1'b1)); // R3
        AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
            (!load_req && step_en && !step_up) |=> tap_out == TAP_W'($past(tap_out) - 1'b1)); // R3
        AST_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
            (!load_req && step_en && step_up && tap_out == '1) |=> tap_out == '0); // R4
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!load_req && !step_en) |=> $stable(tap_out)); // R10
    end

    if (MODE == TAPMODE_STEP) begin : g_ld_init
        AST_LOAD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
            load_req |=> tap_out == RST_TAP); // R5
    end
    if (MODE == TAPMODE_STEP_DIRECT) begin : g_ld_direct
        AST_LOAD_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
            load_req |=> tap_out == $past(load_val)); // R6
    end
    if (MODE == TAPMODE_STEP_STAGED) begin : g_ld_staged
        AST_LOAD_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
            load_req |=> tap_out == $past(stage_out)); // R7
        AST_STAGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            stage_wr |=> stage_out == $past(load_val)); // R8
        AST_STAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            !stage_wr |=> $stable(stage_out)); // R8
    end else begin : g_no_stage
        AST_STAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            stage_out == '0); // R8
    end

    AST_LOAD_OVER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == TAPMODE_STEP_DIRECT && load_req && step_en) |=> tap_out == $past(load_val)); // R9

endmodule

bind tap_delay_ctrl tap_delay_chk #(
    .MODE     (MODE),
    .INIT_TAP (INIT_TAP),
    .TAP_W    (TAP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .step_up   (step_up),
    .load_req  (load_req),
    .load_val  (load_val),
    .stage_wr  (stage_wr),
    .tap_out   (tap_out),
    .stage_out (stage_out)
);

// File: tb/tap_delay_ctrl_tb.sv
`timescale 1ns/1ps
// Drives one instance of each mode from a shared command stream and
// compares all outputs against a behavioural model at every falling edge.
module tap_delay_ctrl_tb;
    import tap_delay_pkg::*;

    localparam int TW = 5;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_en = 1'b0;
    logic          step_up = 1'b0;
    logic          load_req = 1'b0;
    logic [TW-1:0] load_val = '0;
    logic          stage_wr = 1'b0;
    logic [DW-1:0] data_in = '0;

    logic [TW-1:0] tap_o   [4];
    logic [TW-1:0] stage_o [4];
    logic [DW-1:0] dout_o  [4];

    int n_tests = 0;
    int n_fail  = 0;
    bit started = 1'b0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    // Mode 0 fixed, 1 plain stepping, 2 direct load, 3 staged load.
    // INIT 29 for the first two, 17 for the load modes (must be ignored).
    tap_delay_ctrl #(.MODE(TAPMODE_FIXED), .INIT_TAP(29), .TAP_W(TW), .DATA_W(DW)) u_dut_fix (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_up(step_up), .load_req(load_req),
        .load_val(load_val), .stage_wr(stage_wr), .data_in(data_in),
        .tap_out(tap_o[0]), .stage_out(stage_o[0]), .data_out(dout_o[0]));
    tap_delay_ctrl #(.MODE(TAPMODE_STEP), .INIT_TAP(29), .TAP_W(TW), .DATA_W(DW)) u_dut_var (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_up(step_up), .load_req(load_req),
        .load_val(load_val), .stage_wr(stage_wr), .data_in(data_in),
        .tap_out(tap_o[1]), .stage_out(stage_o[1]), .data_out(dout_o[1]));
    tap_delay_ctrl #(.MODE(TAPMODE_STEP_DIRECT), .INIT_TAP(17), .TAP_W(TW), .DATA_W(DW)) u_dut_dir (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_up(step_up), .load_req(load_req),
        .load_val(load_val), .stage_wr(stage_wr), .data_in(data_in),
        .tap_out(tap_o[2]), .stage_out(stage_o[2]), .data_out(dout_o[2]));
    tap_delay_ctrl #(.MODE(TAPMODE_STEP_STAGED), .INIT_TAP(17), .TAP_W(TW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_up(step_up), .load_req(load_req),
        .load_val(load_val), .stage_wr(stage_wr), .data_in(data_in),
        .tap_out(tap_o[3]), .stage_out(stage_o[3]), .data_out(dout_o[3]));

    // Reference model state.
    int    m_tap   [4];
    int    m_stage [4];
    string m_tag   [4];
    int    rst_tap [4] = '{29, 29, 0, 0};
    logic [DW-1:0] hist_q[$];

    // Model update on each rising edge from the inputs then present.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) begin
                m_tap[k] = rst_tap[k]; m_stage[k] = 0; m_tag[k] = "R1";
            end
            hist_q = {};
            for (int i = 0; i < 31; i++) hist_q.push_back('0);
        end else begin
            for (int k = 0; k < 4; k++) begin
                int old_stage;
                old_stage = m_stage[k];
                if (k == 3 && stage_wr) m_stage[k] = int'(load_val);
                if (k == 0) begin
                    m_tag[k] = "R2";
                end else if (load_req) begin
                    m_tap[k] = (k == 1) ? 29 : (k == 2) ? int'(load_val) : old_stage;
                    m_tag[k] = step_en ? "R9" : (k == 1) ? "R5" : (k == 2) ? "R6" : "R7";
                end else if (step_en) begin
                    if (step_up) begin
                        m_tag[k] = (m_tap[k] == 31) ? "R4" : "R3";
                        m_tap[k] = (m_tap[k] + 1) % 32;
                    end else begin
                        m_tag[k] = (m_tap[k] == 0) ? "R4" : "R3";
                        m_tap[k] = (m_tap[k] + 31) % 32;
                    end
                end else begin
                    m_tag[k] = "R10";
                end
            end
            hist_q.push_front(data_in);
            void'(hist_q.pop_back());
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compares every output shortly after each falling edge.
    always @(negedge clk) begin
        #1;
        if (started && !done) begin
            for (int k = 0; k < 4; k++) begin
                int exp_d;
                chk(m_tag[k], $sformatf("tap mode%0d", k), int'(tap_o[k]), m_tap[k]);
                chk("R8", $sformatf("stage mode%0d", k), int'(stage_o[k]), m_stage[k]);
                exp_d = (m_tap[k] == 0) ? int'(data_in) : int'(hist_q[m_tap[k] - 1]);
                chk("R11", $sformatf("data mode%0d", k), int'(dout_o[k]), exp_d);
            end
        end
    end

    // Applies one cycle of stimulus at the falling edge.
    task automatic cyc(input bit en, input bit up, input bit ld, input int val, input bit wr);
        @(negedge clk);
        step_en  = en;
        step_up  = up;
        load_req = ld;
        load_val = TW'(val);
        stage_wr = wr;
        data_in  = DW'($urandom);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) cyc(0, 0, 0, 0, 0);
        @(negedge clk); rst_n = 1'b1;                  // R1 checked next
        repeat (2) cyc(0, 0, 0, 0, 0);                 // R10 idle
        repeat (35) cyc(1, 1, 0, 0, 0);                // R3 up, R4 wrap at 31
        repeat (40) cyc(1, 0, 0, 0, 0);                // R3 down, R4 wrap at 0
        cyc(0, 0, 1, 9, 0);                            // R5 R6 R7 loads
        cyc(0, 0, 0, 0, 0);
        cyc(1, 1, 1, 3, 0);                            // R9 load beats step
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 21, 1);                           // R8 write 21
        cyc(0, 0, 1, 30, 0);                           // R7 load 21
        cyc(0, 0, 1, 7, 1);                            // R7 write+load: old 21
        cyc(0, 0, 1, 12, 0);                           // R7 now 7
        repeat (33) cyc(0, 0, 0, 0, 0);                // R11 long delay
        @(negedge clk); rst_n = 1'b0;                  // R1 mid-run reset
        cyc(1, 1, 1, 5, 1);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 700; i++) begin
            int r;
            r = $urandom_range(0, 99);
            cyc(r < 60, $urandom_range(0, 1) == 1, r >= 85, $urandom_range(0, 31), $urandom_range(0, 3) == 0);
        end
        repeat (3) cyc(0, 0, 0, 0, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("[TB] FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule